// File: doc/BRIEF.md
# CAN Receive Ring Buffer Writer

This block sits behind a CAN controller and files every received frame into a circular buffer held in on-chip storage. Each frame becomes a 16-byte record: two 32-bit header words, then two data words. The block packs the identifier, the frame-type flags, the length code and the controller's error state at reception time into the headers. Software drains the ring. It reads records through a record read port, then moves the read pointer forward through a small register port. Both pointers are byte offsets from the start of the buffer.

Frames enter on a valid/ready handshake. `fr_ready` follows the receive enable bit, so a disabled block holds the controller back. While the block is enabled, every offered frame is taken in the cycle it is offered. If the ring has no free slot, the block takes the frame and discards it. It then marks the overrun bit in the next record it does store. The write pointer is never allowed to land on the read pointer, so the ring keeps one record slot unused. As a result, equal pointers always mean the ring is empty.

Top module: `canrx_ring_writer`

## Requirements
- R1: After reset the write pointer, the read pointer and the available count are 0, the enable bit is 0, the size register holds DEPTH*16 bytes and no overrun is pending.
- R2: `fr_ready` equals the enable bit (register 0, bit 0). A frame is taken only in a cycle where `fr_valid` and `fr_ready` are both high. While the block is disabled, the write pointer does not move.
- R3: Header word 0 (record bits 31:0) has bit 31 set for an extended identifier and bit 30 set for a remote frame. An extended identifier sits in bits 28:0, and bit 29 is 0.
- R4: A standard identifier sits in bits 28:18 of header word 0. Bits 29 and 17:0 are 0.
- R5: Header word 1 (record bits 63:32) carries the length code unchanged in bits 31:28. Bit 1 is bus-off and bit 0 is error-passive, both sampled at acceptance. Bits 27:3 are 0.
- R6: Data byte k of `fr_data` (bits 8k+7:8k) is stored at record bits 64+8k+7:64+8k. Bytes at or beyond min(length code, 8) are stored as zero.
- R7: Each stored frame advances the write pointer by 16. A record written at offset size-16 returns the pointer to 0.
- R8: If advancing the write pointer would make it equal the read pointer, the frame is still taken but discarded, and the write pointer keeps its value.
- R9: After a discarded frame, the next stored record has header word 1 bit 2 set. The record after that has the bit clear, unless another frame was discarded in between.
- R10: `avail` equals ((write pointer - read pointer) mod size) / 16.
- R11: The register port maps address 0 to enable (bit 0), address 1 to size, address 2 to the read pointer and address 3 to the write pointer (read-only). On size and read pointer writes, bits 3:0 are forced to zero. A size write outside 32..DEPTH*16 is ignored. An accepted size write clears both pointers and any pending overrun. Writes to address 3 have no effect.
- R12: When a read pointer write and a frame acceptance fall in the same cycle, the full decision uses the read pointer value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_valid | input | 1 | Frame offered |
| fr_ready | output | 1 | Frame taken when high together with fr_valid |
| fr_ext | input | 1 | Extended identifier flag |
| fr_rtr | input | 1 | Remote frame flag |
| fr_id | input | 29 | Identifier (standard uses bits 10:0) |
| fr_dlc | input | 4 | Data length code |
| fr_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| st_bus_off | input | 1 | Controller bus-off state |
| st_err_passive | input | 1 | Controller error-passive state |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| rec_idx | input | IW | Record slot to read (byte offset / 16) |
| rec_data | output | 128 | Record contents, header word 0 in bits 31:0 |
| wr_ptr | output | PW | Write pointer, bytes |
| avail | output | AVW | Number of stored records |

## Verification
Two functions can land in the same clock edge: software moving the read pointer, and the frame path deciding whether the ring is full. The bench fills a 4-slot ring until frames are discarded. It then drives a read-pointer write and a frame in the same cycle, at a point where only the new pointer value would free a slot. The bench expects that frame to be dropped. It then expects the next frame to be stored with the overrun bit set. A scoreboard compares every stored record against the frames its driver predicted would be kept, so a dropped frame that gets written anyway, or a kept frame that goes missing, shows up as a mismatch.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
  localparam int REC_BYTES = 16;

  // Packed so that hdr0 occupies bits 31:0 of the record.
  typedef struct packed {
    logic [31:0] dat1;
    logic [31:0] dat0;
    logic [31:0] hdr1;
    logic [31:0] hdr0;
  } rec_t;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_SIZE = 2'd1,
    RA_RPTR = 2'd2,
    RA_WPTR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/canrx_rec_pack.sv
module canrx_rec_pack
  import canrx_pkg::*;
(
  input  logic        ext,
  input  logic        rtr,
  input  logic [28:0] id,
  input  logic [3:0]  dlc,
  input  logic [63:0] data,
  input  logic        ovr,
  input  logic        bus_off,
  input  logic        err_passive,
  output rec_t        rec
);
  logic [3:0]  nbytes;
  logic [63:0] masked;

  assign nbytes = (dlc > 4'd8) ? 4'd8 : dlc;

  for (genvar k = 0; k < 8; k++) begin : g_byte
    assign masked[8*k +: 8] = (4'(k) < nbytes) ? data[8*k +: 8] : 8'h00;
  end

  always_comb begin
    rec.hdr0 = '0;
    rec.hdr0[31] = ext;
    rec.hdr0[30] = rtr;
    if (ext) rec.hdr0[28:0]  = id;
    else     rec.hdr0[28:18] = id[10:0];
    rec.hdr1 = {dlc, 25'd0, ovr, bus_off, err_passive};
    rec.dat0 = masked[31:0];
    rec.dat1 = masked[63:32];
  end
endmodule

// File: rtl/canrx_rec_store.sv
module canrx_rec_store
  import canrx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  rec_t          wrec,
  input  logic [IW-1:0] ridx,
  output rec_t          rrec
);
  rec_t slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[widx] <= wrec;
  end

  assign rrec = slots[ridx];
endmodule

// File: rtl/canrx_ring_ctrl.sv
module canrx_ring_ctrl
  import canrx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW  = $clog2(DEPTH * REC_BYTES) + 1,
  localparam int AVW = $clog2(DEPTH)
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic           en,
  output logic [PW-1:0]  size,
  output logic [PW-1:0]  rptr,
  output logic [PW-1:0]  wptr,
  output logic [AVW-1:0] avail,
  output logic           store,
  output logic           ovr_pend
);
  localparam logic [PW-1:0] RB  = PW'(REC_BYTES);
  localparam logic [31:0]   MAXB = 32'(DEPTH * REC_BYTES);

  logic [PW-1:0] size_q, rp_q, wp_q, wp_nxt, diff;
  logic          en_q, ovr_q, full, drop, size_ok, sz_wr, rp_wr;

  assign wp_nxt  = (wp_q >= size_q - RB) ? '0 : wp_q + RB;
  assign full    = (wp_nxt == rp_q);
  assign store   = hit && !full;
  assign drop    = hit && full;
  assign size_ok = (cfg_wdata >= 32'd32) && (cfg_wdata <= MAXB);
  assign sz_wr   = cfg_wr && (cfg_addr == RA_SIZE) && size_ok;
  assign rp_wr   = cfg_wr && (cfg_addr == RA_RPTR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      size_q <= MAXB[PW-1:0];
      rp_q   <= '0;
      wp_q   <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (cfg_wr && cfg_addr == RA_CTRL) en_q <= cfg_wdata[0];
      if (sz_wr) begin
        size_q <= {cfg_wdata[PW-1:4], 4'b0000};
        rp_q   <= '0;
        wp_q   <= '0;
        ovr_q  <= 1'b0;
      end else begin
        if (rp_wr) rp_q <= {cfg_wdata[PW-1:4], 4'b0000};
        if (store) begin
          wp_q  <= wp_nxt;
          ovr_q <= 1'b0;
        end else if (drop) begin
          ovr_q <= 1'b1;
        end
      end
    end
  end

  assign diff  = (wp_q >= rp_q) ? (wp_q - rp_q) : (wp_q + size_q - rp_q);
  assign avail = diff[AVW+3:4];

  assign en       = en_q;
  assign size     = size_q;
  assign rptr     = rp_q;
  assign wptr     = wp_q;
  assign ovr_pend = ovr_q;

  // R8: after a store the write pointer never lands on the read pointer
  p_gap_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> (wp_q != $past(rp_q)));
  // R8: a discarded frame leaves the write pointer alone
  p_drop_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !sz_wr) |=> $stable(wp_q));
  // R9: a discard leaves an overrun pending
  p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr_q);
  // R9: storing a record consumes the pending overrun
  p_ovr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> !ovr_q);
  // R10: a store with no register activity raises the count by one
  p_avail_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !rp_wr && !sz_wr) |=> (avail == $past(avail) + 1'b1));
  // R7: pointers stay record aligned
  p_wp_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q[3:0] == 4'd0);
endmodule

// File: rtl/canrx_ring_writer.sv
module canrx_ring_writer
  import canrx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW  = $clog2(DEPTH),
  localparam int PW  = $clog2(DEPTH * REC_BYTES) + 1,
  localparam int AVW = $clog2(DEPTH)
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fr_valid,
  output logic           fr_ready,
  input  logic           fr_ext,
  input  logic           fr_rtr,
  input  logic [28:0]    fr_id,
  input  logic [3:0]     fr_dlc,
  input  logic [63:0]    fr_data,
  input  logic           st_bus_off,
  input  logic           st_err_passive,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic [IW-1:0]  rec_idx,
  output logic [127:0]   rec_data,
  output logic [PW-1:0]  wr_ptr,
  output logic [AVW-1:0] avail
);
  logic          en, store, ovr_pend, hit;
  logic [PW-1:0] size, rptr, wptr;
  rec_t          new_rec, rd_rec;

  assign fr_ready = en;
  assign hit      = fr_valid && en;

  canrx_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .en(en), .size(size), .rptr(rptr), .wptr(wptr),
    .avail(avail), .store(store), .ovr_pend(ovr_pend)
  );

  canrx_rec_pack u_pack (
    .ext(fr_ext), .rtr(fr_rtr), .id(fr_id), .dlc(fr_dlc), .data(fr_data),
    .ovr(ovr_pend), .bus_off(st_bus_off), .err_passive(st_err_passive),
    .rec(new_rec)
  );

  canrx_rec_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(store), .widx(wptr[IW+3:4]), .wrec(new_rec),
    .ridx(rec_idx), .rrec(rd_rec)
  );

  always_comb begin
    case (cfg_addr)
      RA_CTRL: cfg_rdata = {31'd0, en};
      RA_SIZE: cfg_rdata = 32'(size);
      RA_RPTR: cfg_rdata = 32'(rptr);
      default: cfg_rdata = 32'(wptr);
    endcase
  end

  assign rec_data = rd_rec;
  assign wr_ptr   = wptr;

  // R2: nothing is stored while reception is disabled
  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fr_ready && !cfg_wr) |=> $stable(wr_ptr));
endmodule

// File: tb/canrx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module canrx_ring_writer_tb_top;
  localparam int DEPTH = 16;
  localparam int IW = 4, PW = 9, AVW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr_valid = 1'b0, fr_ext = 1'b0, fr_rtr = 1'b0;
  logic fr_ready;
  logic [28:0] fr_id = '0;
  logic [3:0]  fr_dlc = '0;
  logic [63:0] fr_data = '0;
  logic st_bus_off = 1'b0, st_err_passive = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [IW-1:0] rec_idx = '0;
  logic [127:0] rec_data;
  logic [PW-1:0] wr_ptr;
  logic [AVW-1:0] avail;

  always #2.5 clk = ~clk;

  canrx_ring_writer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_ready(fr_ready),
    .fr_ext(fr_ext), .fr_rtr(fr_rtr), .fr_id(fr_id), .fr_dlc(fr_dlc),
    .fr_data(fr_data), .st_bus_off(st_bus_off), .st_err_passive(st_err_passive),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rec_idx(rec_idx), .rec_data(rec_data),
    .wr_ptr(wr_ptr), .avail(avail)
  );

  int checks = 0, fails = 0;
  logic [127:0] exp_q[$];
  int m_wp = 0, m_rp = 0, m_size = DEPTH * 16;
  bit m_en = 0, m_ovr = 0, resync = 0, done = 0;
  int last_wp = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_rec(bit ext, bit rtr, logic [28:0] id,
      logic [3:0] dlc, logic [63:0] data, bit ovr, bit bo, bit ep);
    logic [31:0] h0, h1;
    logic [63:0] d;
    int n;
    h0 = {ext, rtr, 30'd0};
    if (ext) h0 = h0 | {3'b000, id};
    else     h0 = h0 | (32'(id[10:0]) << 18);
    h1 = {dlc, 25'd0, ovr, bo, ep};
    n = (dlc > 8) ? 8 : int'(dlc);
    d = '0;
    for (int k = 0; k < n; k++) d[8*k +: 8] = data[8*k +: 8];
    return {d, h1, h0};
  endfunction

  // model of one acceptance, using the read pointer held before this edge
  task automatic model_accept(bit ext, bit rtr, logic [28:0] id, logic [3:0] dlc,
      logic [63:0] data, bit bo, bit ep);
    int nxt;
    if (!m_en) return;
    nxt = (m_wp >= m_size - 16) ? 0 : m_wp + 16;
    if (nxt == m_rp) m_ovr = 1;
    else begin
      exp_q.push_back(mk_rec(ext, rtr, id, dlc, data, m_ovr, bo, ep));
      m_ovr = 0;
      m_wp = nxt;
    end
  endtask

  task automatic drive_frame(bit ext, bit rtr, logic [28:0] id, logic [3:0] dlc,
      logic [63:0] data, bit bo, bit ep);
    fr_ext = ext; fr_rtr = rtr; fr_id = id; fr_dlc = dlc; fr_data = data;
    st_bus_off = bo; st_err_passive = ep; fr_valid = 1'b1;
  endtask

  task automatic send(bit ext, bit rtr, logic [28:0] id, logic [3:0] dlc,
      logic [63:0] data, bit bo, bit ep);
    @(negedge clk);
    drive_frame(ext, rtr, id, dlc, data, bo, ep);
    @(posedge clk);
    model_accept(ext, rtr, id, dlc, data, bo, ep);
    @(negedge clk);
    fr_valid = 1'b0;
  endtask

  task automatic model_cfg(logic [1:0] a, logic [31:0] v);
    if (a == 2'd0) m_en = v[0];
    else if (a == 2'd1 && v >= 32 && v <= DEPTH * 16) begin
      m_size = int'(v) & ~15; m_wp = 0; m_rp = 0; m_ovr = 0; resync = 1;
    end else if (a == 2'd2) m_rp = int'(v[PW-1:0]) & ~15;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(posedge clk);
    model_cfg(a, v);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic chk_ptrs(string req);
    @(negedge clk);
    #1;
    chk({req, " wr_ptr"}, 32'(wr_ptr), 32'(m_wp));
    chk({req, " avail"}, 32'(avail), 32'(((m_wp - m_rp + m_size) % m_size) / 16));
  endtask

  // scoreboard monitor: each pointer move exposes one new record
  always begin
    @(negedge clk);
    if (rst_n && !done) begin
      if (resync) begin
        resync = 0;
        last_wp = int'(wr_ptr);
      end else if (int'(wr_ptr) != last_wp) begin
        rec_idx = IW'(last_wp / 16);
        #1;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R3-R9 scoreboard act=%h exp=<none>", rec_data);
        end else begin
          logic [127:0] e;
          e = exp_q.pop_front();
          if (rec_data !== e) begin
            fails++;
            $display("FAIL R3/R4/R5/R6/R9 record act=%h exp=%h", rec_data, e);
          end
        end
        last_wp = int'(wr_ptr);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    chk("R1 wr_ptr", 32'(wr_ptr), 0);
    chk("R1 avail", 32'(avail), 0);
    chk("R1 ready", 32'(fr_ready), 0);
    rd(2'd0, v); chk("R1 enable", v, 0);
    rd(2'd1, v); chk("R1 size", v, DEPTH * 16);
    rd(2'd2, v); chk("R1 rptr", v, 0);

    // R2 disabled: offered frame not taken
    send(0, 0, 29'h55, 4'd2, 64'h1111, 0, 0);
    chk_ptrs("R2 disabled");
    wr(2'd0, 32'd1);
    @(negedge clk); #1 chk("R2 ready", 32'(fr_ready), 1);

    // R3..R6 assorted frames
    send(0, 0, 29'h123, 4'd8, 64'h8877665544332211, 0, 0);
    send(1, 1, 29'h1ABCDEF0, 4'd3, 64'hFFEEDDCCBBAA9988, 1, 0);
    send(0, 1, 29'h7FF, 4'd0, 64'hDEADBEEFCAFEF00D, 0, 1);
    send(1, 0, 29'h00000ABC, 4'd12, 64'h0102030405060708, 1, 1);
    chk_ptrs("R7/R10 four stored");

    // R11 size write: bad value ignored, good value resets pointers
    wr(2'd1, 32'h1000);
    rd(2'd1, v); chk("R11 bad size ignored", v, DEPTH * 16);
    wr(2'd1, 32'd64);
    rd(2'd1, v); chk("R11 size", v, 64);
    rd(2'd2, v); chk("R11 rptr cleared", v, 0);
    chk_ptrs("R11 after size");

    // R8 fill 4-slot ring, fourth frame discarded
    send(0, 0, 29'h10, 4'd1, 64'hA1, 0, 0);
    send(0, 0, 29'h11, 4'd1, 64'hA2, 0, 0);
    send(0, 0, 29'h12, 4'd1, 64'hA3, 0, 0);
    chk_ptrs("R8 three stored");
    send(0, 0, 29'h13, 4'd1, 64'hA4, 0, 0);
    chk_ptrs("R8 full drop");

    // R11 read pointer masked, R10 count, R9 overrun, R7 wrap
    wr(2'd2, 32'h25);
    rd(2'd2, v); chk("R11 rptr masked", v, 32);
    chk_ptrs("R10 after rptr");
    send(1, 0, 29'h14, 4'd2, 64'hB1B2, 0, 0);
    chk_ptrs("R7 wrap to zero");
    send(1, 0, 29'h15, 4'd2, 64'hC1C2, 0, 0);
    chk_ptrs("R9 second clears");

    // R12 same-cycle read pointer write and frame: old pointer decides
    @(negedge clk);
    drive_frame(0, 0, 29'h16, 4'd1, 64'hD1, 0, 0);
    cfg_wr = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'd48;
    @(posedge clk);
    model_accept(0, 0, 29'h16, 4'd1, 64'hD1, 0, 0);
    model_cfg(2'd2, 32'd48);
    @(negedge clk);
    fr_valid = 1'b0; cfg_wr = 1'b0;
    chk_ptrs("R12 same-cycle drop");
    send(0, 1, 29'h17, 4'd5, 64'h0000_00E5E4E3E2E1, 1, 0);
    chk_ptrs("R12 then store");

    // R11 write pointer is read-only
    wr(2'd3, 32'd0);
    chk_ptrs("R11 wptr write ignored");
    rd(2'd3, v); chk("R11 wptr readback", v, 32'(m_wp));

    // R2 disable again
    wr(2'd0, 32'd0);
    @(negedge clk); #1 chk("R2 ready low", 32'(fr_ready), 0);
    send(0, 0, 29'h18, 4'd1, 64'hF1, 0, 0);
    chk_ptrs("R2 no store");

    repeat (3) @(negedge clk);
    chk("R3-R9 queue drained", 32'(exp_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule